// File: doc/BRIEF.md
# Power-Test Load State Controller

This block is the control core of a power-characterisation design. Three debounced push-button pulses drive it. The first pulse steps a four-value frequency setting. The second steps a twenty-level resource-utilisation setting. The third flips an output-drive enable.

From these settings the block produces four things:
- a clock-enable cadence that scales the toggle rate of a bank of replicated load units;
- a thermometer of enables that switches those units on one by one, each unit carrying eight output pins;
- per-unit enables for the output pins;
- status codes for LEDs.

The load units, the debouncers and any power display sit outside the block. The block clocks from the full-rate clock. The load bank toggles only in cycles where the clock-enable is high.

Top module: `pwr_load_ctrl`

## Requirements
- R1: After the asynchronous active-low reset, the frequency code is 2'b00, the resource code is 5'b00000, the output-drive enable and its LED are 0, only unit-enable bit 0 is high, and all pin enables are 0.
- R2: Each single-cycle pulse on the frequency button advances the 2-bit frequency code by one at the clock edge that samples it: 00, 01, 10, 11, then back to 00.
- R3: The resource code is the binary level 0 to 19. Level 0 means 5% and level 19 (5'b10011) means 100%, in steps of 5%.
- R4: Each pulse on the resource button advances the level by one. From 19 it wraps to 0.
- R5: Unit-enable bit i is high exactly when i <= level. The active-pin count output equals 8 × (level+1), which runs from 8 to 160.
- R6: Each pulse on the output button toggles the output-drive enable. The status LED output equals that enable.
- R7: Pin-enable bit i equals unit-enable bit i ANDed with the output-drive enable. All pin enables are 0 while the output drive is off.
- R8: The clock-enable depends on the frequency code:

  | Code | Clock-enable |
  |------|--------------|
  | 00 | always 0 |
  | 01 | high 1 cycle in every 3, never 2 cycles in a row |
  | 10 | high 2 cycles in every 3 |
  | 11 | always 1 |

- R9: Pulses on several buttons in the same cycle each update their own setting in that cycle.
- R10: In a cycle with no pulse on a button, the setting that button controls holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Full-rate clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| freq_btn_i | input | 1 | Frequency step pulse |
| res_btn_i | input | 1 | Resource step pulse |
| oe_btn_i | input | 1 | Output-drive toggle pulse |
| freq_code_o | output | 2 | Frequency LED code |
| res_code_o | output | 5 | Resource LED code (level) |
| oe_led_o | output | 1 | Output-drive status LED |
| clk_en_o | output | 1 | Load toggle clock-enable |
| unit_en_o | output | 20 | Per-unit enables (thermometer) |
| pin_en_o | output | 20 | Per-unit output-pin enables |
| active_pins_o | output | 8 | Number of active output pins |

## Verification
A vector table presses single buttons, pairs of buttons and all three buttons together. It also includes idle cycles. This separates the independent update of each setting from any coupling between them, and separates holding from stepping. The frequency code is taken through all four values including the wrap. The clock-enable is counted over 30-cycle windows, so the cadences of 0, 10, 20 and 30 high cycles cannot be confused. The resource level is driven to 19 and then wrapped, which exercises both ends of the thermometer and the pin count of 160. The pin enables are observed with the output drive both on and off.

// File: rtl/pwr_load_pkg.sv
package pwr_load_pkg;
  typedef enum logic [1:0] {
    FREQ_STOP       = 2'b00,
    FREQ_THIRD      = 2'b01,
    FREQ_TWO_THIRDS = 2'b10,
    FREQ_FULL       = 2'b11
  } freq_e;

  localparam int unsigned CADENCE_LEN = 3;
endpackage

// File: rtl/freq_ctrl.sv
module freq_ctrl
  import pwr_load_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       step_i,
  output logic [1:0] code_o,
  output logic       ce_o
);
  localparam int unsigned PH_W = $clog2(CADENCE_LEN);

  freq_e             freq_q;
  logic [PH_W-1:0]   phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) freq_q <= FREQ_STOP;
    else if (step_i) freq_q <= freq_e'(freq_q + 2'd1);
  end

  // free-running phase, period CADENCE_LEN
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= '0;
    else if (phase_q == PH_W'(CADENCE_LEN - 1)) phase_q <= '0;
    else phase_q <= phase_q + 1'b1;
  end

  always_comb begin
    unique case (freq_q)
      FREQ_STOP:       ce_o = 1'b0;
      FREQ_THIRD:      ce_o = (phase_q == '0);
      FREQ_TWO_THIRDS: ce_o = (phase_q != PH_W'(CADENCE_LEN - 1));
      default:         ce_o = 1'b1;
    endcase
  end

  assign code_o = freq_q;

  AST_FREQ_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> (code_o == 2'($past(code_o) + 2'd1)));  // R2
  AST_FREQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(code_o));  // R10
  AST_CE_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_o == FREQ_FULL) |-> ce_o);  // R8
  AST_CE_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_o == FREQ_STOP) |-> !ce_o);  // R8
  AST_CE_THIRD_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_o == FREQ_THIRD && ce_o && !step_i) |=> !ce_o);  // R8
endmodule

// File: rtl/res_ctrl.sv
module res_ctrl #(
  parameter int unsigned NUM_UNITS = 20,
  localparam int unsigned LVL_W = $clog2(NUM_UNITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  output logic [LVL_W-1:0] level_o
);
  localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(NUM_UNITS - 1);

  logic [LVL_W-1:0] level_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) level_q <= '0;
    else if (step_i) level_q <= (level_q == LVL_MAX) ? '0 : level_q + 1'b1;
  end

  assign level_o = level_q;

  AST_RES_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= LVL_MAX);  // R3
  AST_RES_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && level_o == LVL_MAX) |=> (level_o == '0));  // R4
  AST_RES_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(level_o));  // R10
endmodule

// File: rtl/unit_dec.sv
module unit_dec #(
  parameter int unsigned NUM_UNITS = 20,
  parameter int unsigned PINS_PER_UNIT = 8,
  localparam int unsigned LVL_W = $clog2(NUM_UNITS),
  localparam int unsigned CNT_W = $clog2(NUM_UNITS * PINS_PER_UNIT + 1)
) (
  input  logic [LVL_W-1:0]     level_i,
  input  logic                 oe_i,
  output logic [NUM_UNITS-1:0] unit_en_o,
  output logic [NUM_UNITS-1:0] pin_en_o,
  output logic [CNT_W-1:0]     active_pins_o
);
  for (genvar i = 0; i < NUM_UNITS; i++) begin : g_unit
    assign unit_en_o[i] = (LVL_W'(i) <= level_i);
    assign pin_en_o[i]  = unit_en_o[i] & oe_i;
  end

  assign active_pins_o = CNT_W'((CNT_W'(level_i) + CNT_W'(1)) * CNT_W'(PINS_PER_UNIT));
endmodule

// File: rtl/pwr_load_ctrl.sv
module pwr_load_ctrl #(
  parameter int unsigned NUM_UNITS = 20,
  parameter int unsigned PINS_PER_UNIT = 8,
  localparam int unsigned LVL_W = $clog2(NUM_UNITS),
  localparam int unsigned CNT_W = $clog2(NUM_UNITS * PINS_PER_UNIT + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 freq_btn_i,
  input  logic                 res_btn_i,
  input  logic                 oe_btn_i,
  output logic [1:0]           freq_code_o,
  output logic [LVL_W-1:0]     res_code_o,
  output logic                 oe_led_o,
  output logic                 clk_en_o,
  output logic [NUM_UNITS-1:0] unit_en_o,
  output logic [NUM_UNITS-1:0] pin_en_o,
  output logic [CNT_W-1:0]     active_pins_o
);
  logic             oe_q;
  logic [LVL_W-1:0] level;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) oe_q <= 1'b0;
    else if (oe_btn_i) oe_q <= ~oe_q;
  end

  freq_ctrl u_freq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (freq_btn_i),
    .code_o (freq_code_o),
    .ce_o   (clk_en_o)
  );

  res_ctrl #(.NUM_UNITS(NUM_UNITS)) u_res (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (res_btn_i),
    .level_o (level)
  );

  unit_dec #(.NUM_UNITS(NUM_UNITS), .PINS_PER_UNIT(PINS_PER_UNIT)) u_dec (
    .level_i       (level),
    .oe_i          (oe_q),
    .unit_en_o     (unit_en_o),
    .pin_en_o      (pin_en_o),
    .active_pins_o (active_pins_o)
  );

  assign res_code_o = level;
  assign oe_led_o   = oe_q;

  AST_OE_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_btn_i |=> (oe_led_o != $past(oe_led_o)));  // R6
  AST_UNIT_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(unit_en_o) == int'(res_code_o) + 1);  // R5
  AST_UNIT_BASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unit_en_o[0]);  // R5
  AST_PIN_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_led_o |-> (pin_en_o == '0));  // R7
  AST_PIN_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_led_o |-> (pin_en_o == unit_en_o));  // R7
endmodule

// File: tb/tb_pwr_load_ctrl.sv
module tb_pwr_load_ctrl;
  localparam int NU = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bf = 1'b0, br = 1'b0, bo = 1'b0;
  logic [1:0]    freq_code;
  logic [4:0]    res_code;
  logic          oe_led, clk_en;
  logic [NU-1:0] unit_en, pin_en;
  logic [7:0]    active_pins;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwr_load_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .freq_btn_i(bf), .res_btn_i(br), .oe_btn_i(bo),
    .freq_code_o(freq_code), .res_code_o(res_code), .oe_led_o(oe_led),
    .clk_en_o(clk_en), .unit_en_o(unit_en), .pin_en_o(pin_en),
    .active_pins_o(active_pins)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [NU-1:0] thermo(int lvl);
    logic [NU-1:0] v = '0;
    for (int i = 0; i < NU; i++) if (i <= lvl) v[i] = 1'b1;
    return v;
  endfunction

  task automatic check_state(string req, int f, int r, int o);
    chk({req, " freq"}, freq_code, f);
    chk({req, " res"}, res_code, r);
    chk({req, " led"}, oe_led, o);
    chk({req, " unit_en R5"}, unit_en, thermo(r));
    chk({req, " pins R5"}, active_pins, 8 * (r + 1));
    chk({req, " pin_en R7"}, pin_en, o ? thermo(r) : 0);
  endtask

  task automatic press(logic f, logic r, logic o);
    @(negedge clk);
    bf = f; br = r; bo = o;
    @(negedge clk);
    bf = 1'b0; br = 1'b0; bo = 1'b0;
  endtask

  task automatic count_ce(string req, int exp);
    int cnt = 0;
    logic prev = 1'b0;
    int dbl = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (clk_en) cnt++;
      if (clk_en && prev) dbl++;
      prev = clk_en;
    end
    chk(req, cnt, exp);
    if (exp == 10) chk("R8 no back-to-back at 1/3", dbl, 0);
  endtask

  // {bf, br, bo, exp_freq[1:0], exp_res[4:0], exp_oe}
  localparam logic [10:0] VEC [10] = '{
    {3'b100, 2'd1, 5'd0, 1'b0},  // R2
    {3'b100, 2'd2, 5'd0, 1'b0},  // R2
    {3'b010, 2'd2, 5'd1, 1'b0},  // R4
    {3'b001, 2'd2, 5'd1, 1'b1},  // R6
    {3'b111, 2'd3, 5'd2, 1'b0},  // R9
    {3'b100, 2'd0, 5'd2, 1'b0},  // R2 wrap
    {3'b000, 2'd0, 5'd2, 1'b0},  // R10
    {3'b011, 2'd0, 5'd3, 1'b1},  // R9
    {3'b110, 2'd1, 5'd4, 1'b1},  // R9
    {3'b000, 2'd1, 5'd4, 1'b1}   // R10
  };

  initial begin
    repeat (3) @(negedge clk);
    check_state("R1 reset", 0, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R1 after release", 0, 0, 0);

    for (int k = 0; k < 10; k++) begin
      press(VEC[k][10], VEC[k][9], VEC[k][8]);
      check_state("R2/R4/R6/R9/R10 vector", int'(VEC[k][7:6]), int'(VEC[k][5:1]), int'(VEC[k][0]));
    end

    count_ce("R8 cadence 1/3", 10);
    press(1'b1, 1'b0, 1'b0);
    count_ce("R8 cadence 2/3", 20);
    press(1'b1, 1'b0, 1'b0);
    count_ce("R8 cadence full", 30);
    press(1'b1, 1'b0, 1'b0);
    count_ce("R8 cadence stop", 0);

    for (int k = 0; k < 15; k++) press(1'b0, 1'b1, 1'b0);
    check_state("R3 top level 19", 0, 19, 1);
    chk("R5 all units on", unit_en, 20'hFFFFF);
    chk("R5 pin count 160", active_pins, 160);
    press(1'b0, 1'b1, 1'b1);
    check_state("R4 wrap to 0", 0, 0, 0);

    press(1'b1, 1'b1, 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check_state("R1 mid-run reset", 0, 0, 0);
    rst_n = 1'b1;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule